// File: doc/BRIEF.md
# Power-Fail Supervisor

This block is the digital control logic that sits next to an on-chip supply monitor. An analog comparator outside the block raises a "supply below threshold" level. The block resynchronises that level and filters it. A dip counts as a real power failure only when it lasts for the qualification time, 100 ns by default. Shorter dips are ignored.

A detected failure sets a sticky status bit in one 8-bit control/status register. If reset mode is selected, the block also issues a fixed-length system reset request. Otherwise it only records the event. Software reads and writes the register over a minimal write-strobe/read-data bus and clears the status by writing 0 to it. The block forwards the two threshold-level bits from a configuration source to the comparator unchanged.

Register fields: bit 2 is the detection-off flag, bit 1 is the reset-mode bit and bit 0 is the failure status. Bits 7..3 are unused.

Top module: `pwrfail_supervisor`

## Requirements
- R1: After reset the register reads 0x04 (detection off, record-only mode, no failure), and the reset request is low.
- R2: Bits 7..3 of the register always read 0, and writes to them have no effect.
- R3: While bit 2 reads 1, the status bit never becomes 1 and no reset request starts, whatever the comparator input does.
- R4: The comparator input is sampled on each rising edge and takes effect two edges later. The status bit reads 1 after the edge that comes two edges after the eighth consecutive high sample, which is ten cycles (100 ns) from the first high sample. Any run of fewer than eight high samples does not set the status.
- R5: Once set, the status bit stays 1 after the comparator input returns low, until software clears it.
- R6: A write with bit 0 = 0 clears the status bit, and a write with bit 0 = 1 leaves it unchanged. A detection on the same edge as a clearing write leaves the status at 1.
- R7: With bit 1 = 1 when a failure is detected, the reset request goes high on the same edge as the status and stays high for exactly 8 cycles.
- R8: With bit 1 = 0, a detection raises no reset request.
- R9: One continuous high episode of the comparator input produces at most one detection and one reset pulse, however long it lasts.
- R10: The 2-bit threshold-select output always equals the 2-bit level configuration input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| below_i | input | 1 | Comparator output: supply below threshold |
| lvl_cfg_i | input | 2 | Threshold level from the configuration source |
| lvl_sel_o | output | 2 | Threshold select to the comparator |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data |
| sys_rst_req_o | output | 1 | System reset request |

## Verification
The pulse-length assertion assumes that a new qualified episode cannot start while a reset pulse is still running. This holds because the pulse length (8 cycles) does not exceed the eight-sample filter run plus the low sample that must separate two episodes. The filter assertion counts high samples of the comparator input from reset onward, so it relies on the input being a clean synchronous level after reset. The stimulus drives the input only on falling edges, in runs of random length from 0 to 13 cycles. It also enables and disables detection at random times, so that the interaction between the disable flag and an episode already in progress is exercised.

// File: rtl/pwrfail_supervisor.sv
module pwrfail_supervisor #(
  parameter int CLK_PERIOD_NS = 10,
  parameter int FILTER_NS     = 100,
  parameter int PULSE_CYCLES  = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       below_i,
  input  logic [1:0] lvl_cfg_i,
  output logic [1:0] lvl_sel_o,
  input  logic       reg_wr_i,
  input  logic [7:0] reg_wdata_i,
  output logic [7:0] reg_rdata_o,
  output logic       sys_rst_req_o
);
  localparam int QUAL_CYC = (FILTER_NS + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;
  localparam int RUN_CYC  = (QUAL_CYC > 2) ? QUAL_CYC - 2 : 1;
  localparam int CW       = $clog2(RUN_CYC + 1);
  localparam int PW       = $clog2(PULSE_CYCLES + 1);

  logic          sync1, sync2;
  logic [CW-1:0] run_cnt;
  logic [PW-1:0] pulse_cnt;
  logic          off_q, mode_q, stat_q;
  logic          hit;

  assign lvl_sel_o     = lvl_cfg_i;
  assign reg_rdata_o   = {5'b0, off_q, mode_q, stat_q};
  assign sys_rst_req_o = (pulse_cnt != '0);
  assign hit           = !off_q && sync2 && (run_cnt == CW'(RUN_CYC - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= 1'b0;
      sync2 <= 1'b0;
    end else begin
      sync1 <= below_i;
      sync2 <= sync1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      run_cnt <= '0;
    else if (off_q || !sync2)
      run_cnt <= '0;
    else if (run_cnt != CW'(RUN_CYC))
      run_cnt <= run_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      off_q  <= 1'b1;
      mode_q <= 1'b0;
      stat_q <= 1'b0;
    end else begin
      if (reg_wr_i) begin
        off_q  <= reg_wdata_i[2];
        mode_q <= reg_wdata_i[1];
        if (!reg_wdata_i[0]) stat_q <= 1'b0;
      end
      if (hit) stat_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      pulse_cnt <= '0;
    else if (hit && mode_q)
      pulse_cnt <= PW'(PULSE_CYCLES);
    else if (pulse_cnt != '0)
      pulse_cnt <= pulse_cnt - 1'b1;
  end
endmodule

module pwrfail_supervisor_chk #(
  parameter int RUN_CYC      = 8,
  parameter int PULSE_CYCLES = 8
) (
  input logic       clk,
  input logic       rst_n,
  input logic       below_i,
  input logic       reg_wr_i,
  input logic [7:0] reg_wdata_i,
  input logic [7:0] reg_rdata_o,
  input logic       sys_rst_req_o
);
  logic [15:0] run, run_d1, run_d2, len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run <= '0; run_d1 <= '0; run_d2 <= '0; len <= '0;
    end else begin
      run    <= below_i ? ((run == 16'hffff) ? run : run + 1'b1) : 16'd0;
      run_d1 <= run;
      run_d2 <= run_d1;
      len    <= sys_rst_req_o ? len + 1'b1 : 16'd0;
    end
  end

  assert_filter_min_run_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reg_rdata_o[0]) |-> (run_d2 >= 16'(RUN_CYC)));

  assert_status_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata_o[0] && !(reg_wr_i && !reg_wdata_i[0])) |=> reg_rdata_o[0]);

  assert_off_no_status_R3: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata_o[2] |=> !$rose(reg_rdata_o[0]));

  assert_off_no_request_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata_o[2] && !sys_rst_req_o) |=> !sys_rst_req_o);

  assert_record_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_rdata_o[1] && !sys_rst_req_o) |=> !sys_rst_req_o);

  assert_pulse_length_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sys_rst_req_o) |-> (len == 16'(PULSE_CYCLES)));

  assert_unused_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_i |=> (reg_rdata_o[7:3] == 5'd0));
endmodule

bind pwrfail_supervisor pwrfail_supervisor_chk #(
  .RUN_CYC(RUN_CYC), .PULSE_CYCLES(PULSE_CYCLES)
) i_chk (
  .clk(clk), .rst_n(rst_n), .below_i(below_i), .reg_wr_i(reg_wr_i),
  .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o),
  .sys_rst_req_o(sys_rst_req_o)
);

// File: tb/test_pwrfail_supervisor.sv
module test_pwrfail_supervisor;
  localparam int RUN   = 8;
  localparam int PULSE = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       below = 1'b0;
  logic [1:0] lvl_cfg = 2'b00;
  logic [1:0] lvl_sel;
  logic       wr = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       req;

  int checks = 0, errors = 0, pulses = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pwrfail_supervisor i_pwrfail_supervisor (
    .clk(clk), .rst_n(rst_n), .below_i(below), .lvl_cfg_i(lvl_cfg),
    .lvl_sel_o(lvl_sel), .reg_wr_i(wr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .sys_rst_req_o(req)
  );

  // expected-value model built from the requirements
  logic m_d1, m_d2, m_off, m_mode, m_stat;
  int   m_run, m_pc;

  function automatic logic exp_hit(logic off, logic d2, int run);
    return !off && d2 && (run == RUN - 1);
  endfunction

  function automatic logic [7:0] exp_reg(logic off, logic mode, logic stat);
    return {5'b0, off, mode, stat};
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_d1 <= 0; m_d2 <= 0; m_run <= 0; m_off <= 1; m_mode <= 0; m_stat <= 0; m_pc <= 0;
    end else begin
      automatic logic h = exp_hit(m_off, m_d2, m_run);
      m_d1 <= below;
      m_d2 <= m_d1;
      m_run <= (m_off || !m_d2) ? 0 : ((m_run < RUN) ? m_run + 1 : m_run);
      if (wr) begin
        m_off  <= wdata[2];
        m_mode <= wdata[1];
        if (!wdata[0]) m_stat <= 0;
      end
      if (h) m_stat <= 1;
      m_pc <= (h && m_mode) ? PULSE : ((m_pc > 0) ? m_pc - 1 : 0);
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R5 status bit vs model", 32'(rdata[0]), 32'(m_stat));
      check("R2 register vs model", 32'(rdata), 32'(exp_reg(m_off, m_mode, m_stat)));
      check("R7 reset request vs model", 32'(req), 32'(m_pc != 0));
      check("R10 level pass-through", 32'(lvl_sel), 32'(lvl_cfg));
      if (req) pulses++;
    end
  end

  task automatic wr_reg(logic [7:0] d);
    wr = 1'b1; wdata = d;
    @(negedge clk);
    wr = 1'b0; wdata = 8'h00;
  endtask

  task automatic hold(logic lvl, int n);
    below = lvl;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h1bad5eed));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset register value", 32'(rdata), 32'h04);
    check("R1 reset request low", 32'(req), 0);

    wr_reg(8'hFB);
    check("R2 unused bits read zero", 32'(rdata), 32'h02);

    hold(1, 7); hold(0, 6);
    check("R4 short dip ignored", 32'(rdata[0]), 0);

    pulses = 0;
    hold(1, 9);
    check("R4 not yet set at cycle nine", 32'(rdata[0]), 0);
    hold(1, 1);
    check("R4 set after ten cycles", 32'(rdata[0]), 1);
    hold(1, 30);
    check("R7 pulse length", 32'(pulses), PULSE);
    check("R9 single pulse in long episode", 32'(pulses), PULSE);
    hold(0, 4);
    check("R5 status held after recovery", 32'(rdata[0]), 1);
    wr_reg(8'h03);
    check("R6 writing one keeps status", 32'(rdata[0]), 1);
    wr_reg(8'h02);
    check("R6 writing zero clears status", 32'(rdata[0]), 0);

    wr_reg(8'h00);
    pulses = 0;
    hold(1, 14); hold(0, 3);
    check("R8 record only sets status", 32'(rdata[0]), 1);
    check("R8 record only no request", 32'(pulses), 0);

    wr_reg(8'h00);
    below = 1'b1;
    repeat (9) @(negedge clk);
    wr_reg(8'h00);
    check("R6 detection beats clear", 32'(rdata[0]), 1);
    hold(0, 3);

    wr_reg(8'h06);
    pulses = 0;
    hold(1, 25); hold(0, 3);
    check("R3 disabled no status", 32'(rdata[0]), 0);
    check("R3 disabled no request", 32'(pulses), 0);

    lvl_cfg = 2'b10;
    @(negedge clk);
    check("R10 level select", 32'(lvl_sel), 32'h2);

    repeat (400) begin
      int n = int'($urandom % 14);
      below = ~below;
      lvl_cfg = 2'($urandom);
      repeat (n) begin
        if (($urandom % 9) == 0) wr_reg(8'($urandom) & 8'h07 | ((($urandom % 4) != 0) ? 8'h00 : 8'h04));
        else @(negedge clk);
      end
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule